// File: doc/BRIEF.md
# Stereo Audio Serial Output Port

This block sends a pair of 24-bit two's-complement samples, left then right, most significant bit first, on one serial data line. A bit clock and a word-select clock frame the bits. The port can generate both clocks itself from the system clock, or it can follow clocks that another device supplies. Two frame layouts are available. In the first, the left word sits in the word-select-low half and starts one bit late. In the second, the left word sits in the word-select-high half and starts on the edge.

In master mode the bit clock is the system clock divided by 4, 6 or 8. This matches a system clock of 256, 384 or 512 times the sample rate, with 64 bit clocks in each frame. In slave mode the port counts system clocks and bit clocks over each frame and drives data only while the last frame it measured was legal. A parallel sample pair is written with a one-cycle strobe. The pair is moved into the transmit register at the start of the next left half, so one frame never mixes two pairs. A force-zero input blanks the data while the clocks keep running.

Top module: `aud_ser_tx`

## Requirements
- R1: While rst_ni is low, dat_o, bck_o and ws_o are all 0.
- R2: In master mode the bck_o period is 8, 6 or 4 clk_i cycles for mode_i = 01, 10 or 11 respectively. Each frame is 64 bck_o periods, with 32 periods on each ws_o level.
- R3: With mode_i = 00 (slave), bck_o and ws_o stay at 0. Bit timing is taken from bck_i and ws_i, which are assumed synchronous to clk_i.
- R4: In master mode, dat_o and ws_o change only on the clk_i edge at which bck_o falls. In slave mode, dat_o changes on the first clk_i edge that sees bck_i low after it was high. A receiver samples on the rising bit-clock edge.
- R5: With fmt_i = 0, the left word is sent while word select is 0 and the right word while it is 1. Bit 23 goes out in the second slot after the word-select change, and bits 22..0 follow one per slot.
- R6: With fmt_i = 1, the left word is sent while word select is 1 and the right word while it is 0. Bit 23 goes out in the first slot after the change, and bits 22..0 follow one per slot.
- R7: Every slot of a half-frame that carries no sample bit is 0.
- R8: smp_l_i and smp_r_i are captured when smp_vld_i is 1. A captured pair is first sent in the frame whose left half starts after the capture, so the frame in progress keeps its old pair.
- R9: In slave mode, data is sent only while the last complete frame was legal. A frame is measured from one rising word-select edge to the next. A legal frame is 64 bit clocks over 256, 384 or 512 clk_i cycles, or 48 bit clocks over 384 clk_i cycles. Any other frame, including one of 32 bit clocks, makes dat_o 0.
- R10: In a 48-bit-clock frame with fmt_i = 0, the least significant bit of each word goes out in the first slot of the following half.
- R11: While zero_i is 1, every bit sent is 0, and bck_o and ws_o keep their normal timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (256, 384 or 512 times the sample rate) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | 00 slave; 01 master 512x; 10 master 384x; 11 master 256x |
| fmt_i | input | 1 | 0: word-delayed layout, left on low select; 1: left-aligned layout, left on high select |
| smp_l_i | input | 24 | Left sample, two's complement |
| smp_r_i | input | 24 | Right sample, two's complement |
| smp_vld_i | input | 1 | Capture strobe for the sample pair |
| zero_i | input | 1 | Force all transmitted bits to 0 |
| bck_i | input | 1 | Bit clock from the external source in slave mode |
| ws_i | input | 1 | Word select from the external source in slave mode |
| bck_o | output | 1 | Generated bit clock (master), 0 in slave |
| ws_o | output | 1 | Generated word select (master), 0 in slave |
| dat_o | output | 1 | Serial data |

## Verification
On every master cycle, the assertions check the following. Data and word select move only with a falling bit clock. The bit clock never toggles on two cycles in a row. Blanking zeroes each new bit. The generated clocks stay low in slave mode. The bench scenarios are the only way to show the rest: the bit order and half placement of each layout, the spilled last bit in short frames, the 4, 6 and 8 cycle bit-clock periods, and the per-frame hand-over of new samples. They also show slave frames being accepted or rejected according to their bit count and system-clock count.

// File: rtl/aud_ser_pkg.sv
package aud_ser_pkg;

  typedef enum logic [1:0] {
    MODE_SLAVE = 2'b00,
    MODE_X512  = 2'b01,
    MODE_X384  = 2'b10,
    MODE_X256  = 2'b11
  } clk_mode_e;

  // System clocks per bit-clock half period in master mode
  function automatic logic [2:0] bck_half(input logic [1:0] m);
    case (m)
      2'b01:   return 3'd4;
      2'b10:   return 3'd3;
      default: return 3'd2;
    endcase
  endfunction

endpackage

// File: rtl/aud_ser_mclk.sv
module aud_ser_mclk
  import aud_ser_pkg::*;
#(
  parameter int unsigned FRM_BITS = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] mode_i,
  input  logic       fmt_i,
  output logic       bck_o,
  output logic       ws_o,
  output logic       tick_o,
  output logic       ws_nxt_o
);
  localparam int unsigned BIT_W = $clog2(FRM_BITS);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRM_BITS - 1);
  localparam logic [BIT_W-1:0] HALF_B   = BIT_W'(FRM_BITS / 2);

  logic [2:0]       cnt_q, half_m1;
  logic [BIT_W-1:0] bit_q, bit_nxt;
  logic             bck_q, ws_q, ws_nxt, wrap;

  always_comb begin
    half_m1 = bck_half(mode_i) - 3'd1;
    wrap    = cnt_q >= half_m1;
    bit_nxt = (bit_q == BIT_LAST) ? '0 : bit_q + 1'b1;
    // left half gets the level selected by the format
    ws_nxt  = (bit_nxt < HALF_B) ? fmt_i : ~fmt_i;
    tick_o  = en_i && wrap && bck_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      bck_q <= 1'b0;
      ws_q  <= 1'b0;
      bit_q <= BIT_LAST;
    end else if (!en_i) begin
      cnt_q <= '0;
      bck_q <= 1'b0;
      ws_q  <= 1'b0;
      bit_q <= BIT_LAST;
    end else if (wrap) begin
      cnt_q <= '0;
      bck_q <= ~bck_q;
      if (bck_q) begin
        bit_q <= bit_nxt;
        ws_q  <= ws_nxt;
      end
    end else begin
      cnt_q <= cnt_q + 3'd1;
    end
  end

  assign bck_o    = bck_q;
  assign ws_o     = ws_q;
  assign ws_nxt_o = ws_nxt;
endmodule

// File: rtl/aud_ser_slv_mon.sv
module aud_ser_slv_mon #(
  parameter int unsigned FRM_BITS   = 64,
  parameter int unsigned SHORT_BITS = 48,
  parameter int unsigned RATIO_LO   = 256,
  parameter int unsigned RATIO_MID  = 384,
  parameter int unsigned RATIO_HI   = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bck_i,
  input  logic ws_i,
  output logic tick_o,
  output logic lock_o
);
  localparam int unsigned CLK_W  = $clog2(RATIO_HI) + 1;
  localparam int unsigned BCNT_W = $clog2(FRM_BITS) + 1;

  logic              bck_q, ws_tk_q, lock_q;
  logic [CLK_W-1:0]  clk_cnt_q;
  logic [BCNT_W-1:0] bit_cnt_q;
  logic              tick, frm_start, clk_sat, r_lo, r_mid, r_hi, len_ok;

  always_comb begin
    tick      = bck_q & ~bck_i;
    frm_start = tick & ws_i & ~ws_tk_q;
    clk_sat   = &clk_cnt_q;
    r_lo      = clk_cnt_q == CLK_W'(RATIO_LO - 1);
    r_mid     = clk_cnt_q == CLK_W'(RATIO_MID - 1);
    r_hi      = clk_cnt_q == CLK_W'(RATIO_HI - 1);
    len_ok    = ((bit_cnt_q == BCNT_W'(FRM_BITS - 1)) && (r_lo || r_mid || r_hi)) ||
                ((bit_cnt_q == BCNT_W'(SHORT_BITS - 1)) && r_mid);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bck_q     <= 1'b0;
      ws_tk_q   <= 1'b0;
      lock_q    <= 1'b0;
      clk_cnt_q <= '0;
      bit_cnt_q <= '0;
    end else begin
      bck_q <= bck_i;
      if (tick) ws_tk_q <= ws_i;
      if (frm_start) begin
        clk_cnt_q <= '0;
        bit_cnt_q <= '0;
        lock_q    <= len_ok;
      end else begin
        if (!clk_sat) clk_cnt_q <= clk_cnt_q + 1'b1;
        else          lock_q    <= 1'b0;
        if (tick && !(&bit_cnt_q)) bit_cnt_q <= bit_cnt_q + 1'b1;
      end
    end
  end

  assign tick_o = tick;
  assign lock_o = lock_q;
endmodule

// File: rtl/aud_ser_shift.sv
module aud_ser_shift #(
  parameter int unsigned SMP_W    = 24,
  parameter int unsigned FRM_BITS = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ws_i,
  input  logic             fmt_i,
  input  logic             en_i,
  input  logic             zero_i,
  input  logic [SMP_W-1:0] smp_l_i,
  input  logic [SMP_W-1:0] smp_r_i,
  input  logic             smp_vld_i,
  output logic             dat_o
);
  localparam int unsigned SLOT_W = $clog2(FRM_BITS);
  localparam int unsigned IDX_W  = $clog2(SMP_W);
  localparam logic [SLOT_W-1:0] SLOT_MAX = '1;
  localparam logic [SLOT_W-1:0] SMP_LAST = SLOT_W'(SMP_W - 1);
  localparam logic [SLOT_W-1:0] SMP_CNT  = SLOT_W'(SMP_W);

  logic [SMP_W-1:0]  l_hold_q, r_hold_q, l_frm_q, r_frm_q, cur_w, prv_w;
  logic [SLOT_W-1:0] slot_q, slot_n;
  logic              ws_tk_q, dat_q, new_half, left_now, enter_left, bit_v;
  logic [IDX_W-1:0]  idx;

  always_comb begin
    new_half   = ws_i != ws_tk_q;
    slot_n     = new_half ? '0 : ((slot_q == SLOT_MAX) ? slot_q : slot_q + 1'b1);
    left_now   = ws_i == fmt_i;
    enter_left = new_half && left_now;
    cur_w      = left_now ? (enter_left ? l_hold_q : l_frm_q) : r_frm_q;
    prv_w      = left_now ? r_frm_q : l_frm_q;
    bit_v      = 1'b0;
    idx        = '0;
    if (fmt_i) begin
      if (slot_n < SMP_CNT) begin
        idx   = IDX_W'(SMP_LAST - slot_n);
        bit_v = cur_w[idx];
      end
    end else if (slot_n != '0 && slot_n <= SMP_CNT) begin
      idx   = IDX_W'(SMP_CNT - slot_n);
      bit_v = cur_w[idx];
    end else if (new_half && slot_q == SMP_LAST) begin
      // previous half was exactly one word long: its last bit spills here
      bit_v = prv_w[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l_hold_q <= '0;
      r_hold_q <= '0;
      l_frm_q  <= '0;
      r_frm_q  <= '0;
      slot_q   <= '0;
      ws_tk_q  <= 1'b0;
      dat_q    <= 1'b0;
    end else begin
      if (smp_vld_i) begin
        l_hold_q <= smp_l_i;
        r_hold_q <= smp_r_i;
      end
      if (tick_i) begin
        ws_tk_q <= ws_i;
        slot_q  <= slot_n;
        dat_q   <= bit_v & en_i & ~zero_i;
        if (enter_left) begin
          l_frm_q <= l_hold_q;
          r_frm_q <= r_hold_q;
        end
      end
    end
  end

  assign dat_o = dat_q;
endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
  import aud_ser_pkg::*;
#(
  parameter int unsigned SMP_W      = 24,
  parameter int unsigned FRM_BITS   = 64,
  parameter int unsigned SHORT_BITS = 48,
  parameter int unsigned RATIO_LO   = 256,
  parameter int unsigned RATIO_MID  = 384,
  parameter int unsigned RATIO_HI   = 512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             fmt_i,
  input  logic [SMP_W-1:0] smp_l_i,
  input  logic [SMP_W-1:0] smp_r_i,
  input  logic             smp_vld_i,
  input  logic             zero_i,
  input  logic             bck_i,
  input  logic             ws_i,
  output logic             bck_o,
  output logic             ws_o,
  output logic             dat_o
);
  clk_mode_e mode;
  logic      master, m_tick, m_ws_nxt, s_tick, s_lock, tick, ws_eng, en;

  assign mode   = clk_mode_e'(mode_i);
  assign master = mode != MODE_SLAVE;

  aud_ser_mclk #(.FRM_BITS(FRM_BITS)) u_mclk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (master),
    .mode_i   (mode_i),
    .fmt_i    (fmt_i),
    .bck_o    (bck_o),
    .ws_o     (ws_o),
    .tick_o   (m_tick),
    .ws_nxt_o (m_ws_nxt)
  );

  aud_ser_slv_mon #(
    .FRM_BITS   (FRM_BITS),
    .SHORT_BITS (SHORT_BITS),
    .RATIO_LO   (RATIO_LO),
    .RATIO_MID  (RATIO_MID),
    .RATIO_HI   (RATIO_HI)
  ) u_slv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bck_i  (bck_i),
    .ws_i   (ws_i),
    .tick_o (s_tick),
    .lock_o (s_lock)
  );

  assign tick   = master ? m_tick : s_tick;
  assign ws_eng = master ? m_ws_nxt : ws_i;
  assign en     = master | s_lock;

  aud_ser_shift #(.SMP_W(SMP_W), .FRM_BITS(FRM_BITS)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .ws_i      (ws_eng),
    .fmt_i     (fmt_i),
    .en_i      (en),
    .zero_i    (zero_i),
    .smp_l_i   (smp_l_i),
    .smp_r_i   (smp_r_i),
    .smp_vld_i (smp_vld_i),
    .dat_o     (dat_o)
  );
endmodule

// File: rtl/aud_ser_tx_chk.sv
module aud_ser_tx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_i,
  input logic       zero_i,
  input logic       bck_o,
  input logic       ws_o,
  input logic       dat_o
);
  assert_idle_clk_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00 && $past(mode_i) == 2'b00) |-> (!bck_o && !ws_o));

  assert_dat_on_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_i) != 2'b00 && dat_o != $past(dat_o)) |-> ($past(bck_o) && !bck_o));

  assert_ws_on_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_i) != 2'b00 && ws_o != $past(ws_o)) |-> ($past(bck_o) && !bck_o));

  assert_zero_bits_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_i) != 2'b00 && $past(zero_i) && $past(bck_o) && !bck_o) |-> !dat_o);

  assert_bck_min_half_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'b00 && mode_i == $past(mode_i) && mode_i == $past(mode_i, 2) &&
     mode_i == $past(mode_i, 3) && bck_o != $past(bck_o)) |-> ($past(bck_o) == $past(bck_o, 2)));
endmodule

bind aud_ser_tx aud_ser_tx_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .mode_i (mode_i),
  .zero_i (zero_i),
  .bck_o  (bck_o),
  .ws_o   (ws_o),
  .dat_o  (dat_o)
);

// File: tb/aud_ser_tx_tb.sv
module aud_ser_tx_tb;
  logic        clk, rst_ni, fmt, vld, zero, bck_i, ws_i, bck_o, ws_o, dat_o;
  logic [1:0]  mode;
  logic [23:0] smp_l, smp_r;
  int n_chk = 0, n_err = 0;

  // slave clock source controls
  logic sl_en = 1'b0, sl_fmt = 1'b0;
  int   sl_div = 8, sl_bits = 64;

  logic bits_a [0:319];
  logic ws_a   [0:319];
  int   rec_n;

  typedef struct packed {
    logic [1:0]  mode;
    logic        fmt;
    logic        zero;
    logic [23:0] l;
    logic [23:0] r;
    logic [3:0]  div;
    logic [6:0]  bits;
    logic        ok;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd3, 1'b0, 1'b0, 24'h800001, 24'h7FFFFE, 4'd0, 7'd0,  1'b1},
    '{2'd2, 1'b0, 1'b0, 24'h123456, 24'hABCDEF, 4'd0, 7'd0,  1'b1},
    '{2'd1, 1'b1, 1'b0, 24'hA5A5A5, 24'h5A5A5A, 4'd0, 7'd0,  1'b1},
    '{2'd3, 1'b1, 1'b0, 24'hFFFFFF, 24'h000001, 4'd0, 7'd0,  1'b1},
    '{2'd1, 1'b0, 1'b1, 24'hFFFFFF, 24'hFFFFFF, 4'd0, 7'd0,  1'b1},
    '{2'd0, 1'b0, 1'b0, 24'hC00003, 24'h3C3C3C, 4'd4, 7'd64, 1'b1},
    '{2'd0, 1'b1, 1'b0, 24'h0F0F0F, 24'hF0F0F1, 4'd8, 7'd64, 1'b1},
    '{2'd0, 1'b0, 1'b0, 24'h9ABCDF, 24'h800001, 4'd8, 7'd48, 1'b1},
    '{2'd0, 1'b1, 1'b0, 24'h654321, 24'hFEDCBA, 4'd8, 7'd48, 1'b1},
    '{2'd0, 1'b0, 1'b0, 24'hFFFFFF, 24'hFFFFFF, 4'd6, 7'd48, 1'b0},
    '{2'd0, 1'b0, 1'b0, 24'hFFFFFF, 24'hFFFFFF, 4'd8, 7'd32, 1'b0},
    '{2'd0, 1'b1, 1'b0, 24'h3FFFFF, 24'hC00000, 4'd6, 7'd64, 1'b1}
  };

  aud_ser_tx u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .fmt_i(fmt),
    .smp_l_i(smp_l), .smp_r_i(smp_r), .smp_vld_i(vld), .zero_i(zero),
    .bck_i(bck_i), .ws_i(ws_i), .bck_o(bck_o), .ws_o(ws_o), .dat_o(dat_o)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  // external bit/word clock source for slave mode, changes on falling clk
  initial begin
    int ph, bn;
    ph = 0; bn = 0; bck_i = 1'b0; ws_i = 1'b0;
    forever begin
      @(negedge clk);
      if (!sl_en) begin
        bck_i = 1'b0; ws_i = 1'b0; ph = 0; bn = 0;
      end else begin
        if (ph == 0) begin
          bck_i = 1'b0;
          bn = (bn + 1) % sl_bits;
          ws_i = (bn < sl_bits / 2) ? sl_fmt : ~sl_fmt;
        end else if (ph == sl_div / 2) begin
          bck_i = 1'b1;
        end
        ph = (ph + 1) % sl_div;
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic load(input logic [23:0] l, input logic [23:0] r);
    @(negedge clk);
    smp_l = l; smp_r = r; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
  endtask

  // capture dat and word select at each rising bit clock
  task automatic record(input int n, input bit master);
    logic p, c;
    rec_n = 0;
    p = master ? bck_o : bck_i;
    while (rec_n < n) begin
      @(posedge clk); #1;
      c = master ? bck_o : bck_i;
      if (c && !p) begin
        bits_a[rec_n] = dat_o;
        ws_a[rec_n]   = master ? ws_o : ws_i;
        rec_n++;
      end
      p = c;
    end
  endtask

  task automatic decode(input int from, input logic f, output logic [23:0] l,
                        output logic [23:0] r, output int pad, output int li, output int ri);
    int off;
    off = f ? 0 : 1;
    li = -1; ri = -1; l = '0; r = '0; pad = 0;
    for (int k = (from < 1 ? 1 : from); k < rec_n; k++)
      if (ws_a[k] == f && ws_a[k-1] != f) begin li = k; break; end
    if (li >= 0)
      for (int k = li + 1; k < rec_n; k++)
        if (ws_a[k] != f && ws_a[k-1] == f) begin ri = k; break; end
    if (li < 0 || ri < 0 || ri + off + 24 > rec_n) begin
      pad = 99;
    end else begin
      for (int b = 0; b < 24; b++) begin
        l[23-b] = bits_a[li+off+b];
        r[23-b] = bits_a[ri+off+b];
      end
      for (int k = li + off + 24; k < ri; k++) if (bits_a[k]) pad++;
    end
  endtask

  task automatic measure(output int per);
    logic p;
    repeat (20) @(posedge clk);
    #1; p = bck_o;
    forever begin
      @(posedge clk); #1;
      if (bck_o && !p) break;
      p = bck_o;
    end
    per = 0; p = 1'b1;
    forever begin
      @(posedge clk); #1;
      per++;
      if (bck_o && !p) break;
      p = bck_o;
    end
  endtask

  initial begin
    int per, pad, li, ri, bad, st, i0;
    logic [23:0] gl, gr, el, er;
    logic pd, pw, pb;
    string tag;
    rst_ni = 1'b0; mode = 2'd3; fmt = 1'b0; zero = 1'b0;
    smp_l = '0; smp_r = '0; vld = 1'b0;
    repeat (5) @(posedge clk); #1;
    check(!dat_o && !bck_o && !ws_o, "R1", "reset outputs",
          {45'd0, dat_o, bck_o, ws_o}, 48'd0);
    @(negedge clk) rst_ni = 1'b1;

    // R2: bit clock period per ratio
    for (int m = 1; m < 4; m++) begin
      @(negedge clk) mode = 2'(m);
      measure(per);
      check(per == ((m == 1) ? 8 : (m == 2) ? 6 : 4), "R2", "bck_o period",
            48'(per), 48'((m == 1) ? 8 : (m == 2) ? 6 : 4));
    end

    // R4: data and word select move only with falling bck_o
    @(negedge clk) begin mode = 2'd2; fmt = 1'b1; end
    load(24'hA5C3E1, 24'h5A3C1E);
    @(posedge clk); #1;
    pd = dat_o; pw = ws_o; pb = bck_o; bad = 0;
    repeat (600) begin
      @(posedge clk); #1;
      if ((dat_o != pd || ws_o != pw) && !(pb && !bck_o)) bad++;
      pd = dat_o; pw = ws_o; pb = bck_o;
    end
    check(bad == 0, "R4", "changes off falling edge", 48'(bad), 48'd0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      mode = VECS[v].mode; fmt = VECS[v].fmt; zero = VECS[v].zero;
      sl_fmt = VECS[v].fmt; sl_div = int'(VECS[v].div); sl_bits = int'(VECS[v].bits);
      sl_en = (VECS[v].mode == 2'd0);
      load(VECS[v].l, VECS[v].r);
      record(280, VECS[v].mode != 2'd0);
      decode(140, VECS[v].fmt, gl, gr, pad, li, ri);
      if (VECS[v].ok && !VECS[v].zero) begin el = VECS[v].l; er = VECS[v].r; end
      else begin el = '0; er = '0; end
      if (VECS[v].zero)                                tag = "R11";
      else if (!VECS[v].ok)                            tag = "R9";
      else if (VECS[v].bits == 7'd48 && !VECS[v].fmt)  tag = "R10";
      else if (VECS[v].fmt)                            tag = "R6";
      else                                             tag = "R5";
      check(gl == el && gr == er, tag, $sformatf("vector %0d words", v),
            {gl, gr}, {el, er});
      check(pad == 0, "R7", $sformatf("vector %0d padding", v), 48'(pad), 48'd0);
      if (VECS[v].mode != 2'd0)
        check(ri - li == 32, "R2", $sformatf("vector %0d half length", v),
              48'(ri - li), 48'd32);
      else begin
        #1;
        check(!bck_o && !ws_o, "R3", $sformatf("vector %0d slave clocks idle", v),
              {46'd0, bck_o, ws_o}, 48'd0);
      end
    end

    // R8: a pair written mid-frame waits for the next left half
    @(negedge clk) begin sl_en = 1'b0; mode = 2'd3; fmt = 1'b0; zero = 1'b0; end
    load(24'h111111, 24'h222222);
    st = 0;
    fork
      record(280, 1'b1);
      begin
        wait (rec_n >= 150);
        forever begin
          @(negedge clk);
          if (rec_n >= 2 && !ws_a[rec_n-1] && !ws_a[rec_n-2]) break;
        end
        smp_l = 24'h333333; smp_r = 24'h444444; vld = 1'b1;
        st = rec_n;
        @(negedge clk) vld = 1'b0;
      end
    join
    i0 = 1;
    for (int k = st - 1; k >= 1; k--)
      if (!ws_a[k] && ws_a[k-1]) begin i0 = k; break; end
    decode(i0, 1'b0, gl, gr, pad, li, ri);
    check(gl == 24'h111111 && gr == 24'h222222, "R8", "frame in progress keeps old pair",
          {gl, gr}, {24'h111111, 24'h222222});
    decode(i0 + 1, 1'b0, gl, gr, pad, li, ri);
    check(gl == 24'h333333 && gr == 24'h444444, "R8", "next frame takes new pair",
          {gl, gr}, {24'h333333, 24'h444444});

    summary();
    $finish;
  end
endmodule